// File: doc/BRIEF.md
# Configurable Link and Speed Status LED Driver

This block turns the link state, transmit and receive activity strobes and the negotiated speed of an Ethernet port into two status LED outputs. A two-bit configuration word, made of a speed-display select and a steady-link select, picks one of four display schemes. The first LED always reflects the link. Depending on the scheme it either glows steadily or blinks off briefly when traffic passes. The second LED either shows the line rate or is released, which the block signals through a dedicated output-enable.

Activity strobes are often a single clock wide, so a built-in blink timer stretches each one into a visible blink. The blink period is a parameter given in clock cycles. A strobe seen while the timer is idle starts a period. During the first half of that period the link LED goes dark, and during the second half it is lit again. If any further activity arrives during a period, a new period starts as soon as the current one ends. Without further activity the timer returns to idle.

Top module: `led_status_drv`

## Requirements
- R1: While reset is asserted (synchronous, active low), the link LED, the speed LED and its enable are all 0, and the blink timer is idle.
- R2: With speed select 0 and steady select 0, the link LED follows the link and blinks on activity, and the speed LED enable is 0.
- R3: With speed select 1 and steady select 0, the link LED follows the link and blinks on activity. The speed LED enable is 1, and the speed LED is 1 at 100 Mb/s and 0 at 10 Mb/s.
- R4: With speed select 1 and steady select 1, the link LED equals the link with no blinking, whatever the activity, and the speed LED shows the speed as in R3.
- R5: With speed select 0 and steady select 1, the link LED equals the link with no blinking, and the speed LED enable is 0.
- R6: A TX or RX strobe while the timer is idle and the link is up starts a period of BLINK_CYCLES cycles. In a blinking scheme the link LED is 0 during the first BLINK_CYCLES/2 cycles of each period and 1 for the rest of the period.
- R7: A strobe seen during a period, including one in its last cycle, makes a new period start right after the current one. Without such a strobe the timer goes idle when the period ends.
- R8: While the link is down, the link LED and the speed LED are 0 and the blink timer is cleared, whatever the activity, speed and configuration inputs are.
- R9: Whenever the speed LED enable is 0, the speed LED is 0.
- R10: Every output is registered. A change of configuration, link, speed or activity input is visible at the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_up | input | 1 | Link is good |
| tx_act | input | 1 | Transmit activity strobe |
| rx_act | input | 1 | Receive activity strobe |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| cfg_speed_sel | input | 1 | 1 = the second LED shows the speed, 0 = released |
| cfg_steady_sel | input | 1 | 1 = steady link LED, 0 = blink on activity |
| led_link | output | 1 | Link / activity LED, 1 = on |
| led_speed | output | 1 | Speed LED value, 1 = on |
| led_speed_oe | output | 1 | Output enable for the speed LED, 0 = high impedance |

## Verification
A wrong count or a lost pending flag in the blink timer shows up at the link LED pin. The LED goes dark or lights up again on the wrong cycle, or a restarted period fails to appear. This is visible at the latest within one blink period of the fault, and the per-cycle comparison catches it on the first cycle where the pin differs. A wrong scheme decode shows up on the speed LED enable or on a missing blink at the first activity strobe after the configuration is applied. A timer that fails to clear on link loss shows up as a shortened dark phase after the link comes back.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

  // Display scheme, encoded as {speed select, steady select}
  typedef enum logic [1:0] {
    SCH_BLINK_ONLY   = 2'b00,
    SCH_STEADY_ONLY  = 2'b01,
    SCH_BLINK_SPEED  = 2'b10,
    SCH_STEADY_SPEED = 2'b11
  } scheme_e;

  function automatic logic scheme_blinks(input scheme_e s);
    return (s == SCH_BLINK_ONLY) || (s == SCH_BLINK_SPEED);
  endfunction

  function automatic logic scheme_shows_speed(input scheme_e s);
    return (s == SCH_BLINK_SPEED) || (s == SCH_STEADY_SPEED);
  endfunction

  // Dark phase: first half of a running period
  function automatic logic in_dark_half(input logic running,
                                        input int unsigned pos,
                                        input int unsigned half);
    return running && (pos < half);
  endfunction

endpackage

// File: rtl/led_blink_timer.sv
module led_blink_timer
  import led_drv_pkg::*;
#(
  parameter int unsigned PERIOD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic activity,
  output logic busy,
  output logic dark_nxt
);
  localparam int unsigned CW   = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam int unsigned HALF = PERIOD / 2;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic          run_q, run_n;
  logic          pend_q, pend_n;
  logic [CW-1:0] pos_q, pos_n;
  logic          period_end;
  logic          restart_evt;
  logic          start_evt;
  logic          expire_evt;

  assign period_end  = run_q && (pos_q == LAST);
  assign start_evt   = link_up && !run_q && activity;
  assign restart_evt = link_up && period_end && (pend_q || activity);
  assign expire_evt  = link_up && period_end && !pend_q && !activity;

  always_comb begin
    run_n  = run_q;
    pend_n = pend_q;
    pos_n  = pos_q;
    if (!link_up) begin
      run_n  = 1'b0;
      pend_n = 1'b0;
      pos_n  = '0;
    end else if (!run_q) begin
      if (activity) begin
        run_n  = 1'b1;
        pend_n = 1'b0;
        pos_n  = '0;
      end
    end else if (period_end) begin
      run_n  = pend_q || activity;
      pend_n = 1'b0;
      pos_n  = '0;
    end else begin
      pos_n  = pos_q + 1'b1;
      pend_n = pend_q || activity;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pend_q <= 1'b0;
      pos_q  <= '0;
    end else begin
      run_q  <= run_n;
      pend_q <= pend_n;
      pos_q  <= pos_n;
    end
  end

  assign busy     = run_q;
  assign dark_nxt = in_dark_half(run_n, int'(pos_n), HALF);

  assert_start_from_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (run_q && pos_q == '0));

  assert_restart_runs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> (run_q && pos_q == '0 && !pend_q));

  assert_expire_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> !run_q);

  assert_cleared_nolink_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> (!run_q && !pend_q));

endmodule

// File: rtl/led_scheme_decode.sv
module led_scheme_decode
  import led_drv_pkg::*;
(
  input  logic cfg_speed_sel,
  input  logic cfg_steady_sel,
  output logic blink_en,
  output logic speed_en
);
  scheme_e scheme;

  assign scheme   = scheme_e'({cfg_speed_sel, cfg_steady_sel});
  assign blink_en = scheme_blinks(scheme);
  assign speed_en = scheme_shows_speed(scheme);

endmodule

// File: rtl/led_out_stage.sv
module led_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic speed_100,
  input  logic blink_en,
  input  logic speed_en,
  input  logic dark_nxt,
  output logic led_link,
  output logic led_speed,
  output logic led_speed_oe
);
  logic link_n, speed_n, oe_n;

  assign link_n  = link_up && !(blink_en && dark_nxt);
  assign oe_n    = speed_en;
  assign speed_n = speed_en && link_up && speed_100;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_link     <= 1'b0;
      led_speed    <= 1'b0;
      led_speed_oe <= 1'b0;
    end else begin
      led_link     <= link_n;
      led_speed    <= speed_n;
      led_speed_oe <= oe_n;
    end
  end

  assert_released_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !led_speed_oe |-> !led_speed);

endmodule

// File: rtl/led_status_drv.sv
module led_status_drv #(
  parameter int unsigned BLINK_CYCLES = 6250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic link_up,
  input  logic tx_act,
  input  logic rx_act,
  input  logic speed_100,
  input  logic cfg_speed_sel,
  input  logic cfg_steady_sel,
  output logic led_link,
  output logic led_speed,
  output logic led_speed_oe
);
  logic activity;
  logic blink_en, speed_en;
  logic timer_busy, dark_nxt;

  assign activity = tx_act || rx_act;

  led_scheme_decode u_dec (
    .cfg_speed_sel (cfg_speed_sel),
    .cfg_steady_sel(cfg_steady_sel),
    .blink_en      (blink_en),
    .speed_en      (speed_en)
  );

  led_blink_timer #(.PERIOD(BLINK_CYCLES)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .link_up (link_up),
    .activity(activity),
    .busy    (timer_busy),
    .dark_nxt(dark_nxt)
  );

  led_out_stage u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_up     (link_up),
    .speed_100   (speed_100),
    .blink_en    (blink_en),
    .speed_en    (speed_en),
    .dark_nxt    (dark_nxt),
    .led_link    (led_link),
    .led_speed   (led_speed),
    .led_speed_oe(led_speed_oe)
  );

  assert_nolink_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |=> (!led_link && !led_speed));

  assert_steady_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && cfg_steady_sel) |=> led_link);

  assert_oe_tracks_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (led_speed_oe == $past(cfg_speed_sel)));

  assert_blink_starts_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (BLINK_CYCLES >= 2 && link_up && activity && !timer_busy && !cfg_steady_sel)
      |=> !led_link);

endmodule

// File: tb/led_status_drv_tb.sv
`timescale 1ns/100ps
module led_status_drv_tb;
  localparam int unsigned PER  = 8;
  localparam int unsigned HALF = PER / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic link_up = 0, tx_act = 0, rx_act = 0, speed_100 = 0;
  logic cfg_speed_sel = 0, cfg_steady_sel = 0;
  logic led_link, led_speed, led_speed_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // reference state
  bit m_run = 0, m_pend = 0;
  int m_pos = 0;
  bit e_link = 0, e_speed = 0, e_oe = 0;

  always #2.5 clk = ~clk;

  led_status_drv #(.BLINK_CYCLES(PER)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .tx_act(tx_act),
    .rx_act(rx_act), .speed_100(speed_100), .cfg_speed_sel(cfg_speed_sel),
    .cfg_steady_sel(cfg_steady_sel), .led_link(led_link),
    .led_speed(led_speed), .led_speed_oe(led_speed_oe));

  // advance the reference model by one clock edge, using the driven inputs
  task automatic model_edge();
    bit act;
    bit dark;
    act = tx_act | rx_act;
    if (!rst_n) begin
      m_run = 0; m_pend = 0; m_pos = 0;
      e_link = 0; e_speed = 0; e_oe = 0;
      return;
    end
    if (!link_up) begin
      m_run = 0; m_pend = 0; m_pos = 0;
    end else if (!m_run) begin
      if (act) begin m_run = 1; m_pos = 0; m_pend = 0; end
    end else if (m_pos == PER - 1) begin
      m_run = m_pend | act; m_pos = 0; m_pend = 0;
    end else begin
      m_pos = m_pos + 1; m_pend = m_pend | act;
    end
    dark = m_run && (m_pos < HALF);
    e_link  = link_up && !(!cfg_steady_sel && dark);
    e_oe    = cfg_speed_sel;
    e_speed = cfg_speed_sel && link_up && speed_100;
  endtask

  task automatic step(input string tag);
    model_edge();
    @(posedge clk);
    #1;
    n_cmp++;
    if (led_link !== e_link || led_speed !== e_speed || led_speed_oe !== e_oe) begin
      n_bad++;
      $display("FAIL %s t=%0t actual link=%b speed=%b oe=%b expected link=%b speed=%b oe=%b",
               tag, $time, led_link, led_speed, led_speed_oe, e_link, e_speed, e_oe);
    end
    @(negedge clk);
  endtask

  task automatic set_cfg(input bit spd, input bit stdy);
    cfg_speed_sel = spd; cfg_steady_sel = stdy;
  endtask

  task automatic pulse(input string tag, input bit tx, input bit rx);
    tx_act = tx; rx_act = rx;
    step(tag);
    tx_act = 0; rx_act = 0;
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(5.0 * 20000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset with every input active
    link_up = 1; tx_act = 1; speed_100 = 1; set_cfg(1, 0);
    idle("R1", 3);
    tx_act = 0;
    rst_n = 1;

    // R2: scheme 00, single strobe blinks, speed LED released
    set_cfg(0, 0); speed_100 = 1;
    idle("R2", 2);
    pulse("R2", 1, 0);
    idle("R6", PER + 3);

    // R6 / R7: strobe mid period restarts, last-cycle strobe restarts
    pulse("R6", 0, 1);
    idle("R6", 3);
    pulse("R7", 1, 0);
    idle("R7", PER - 4);
    idle("R7", 2);
    idle("R7", PER - 3);
    pulse("R7", 0, 1);            // last cycle of the restarted period
    idle("R7", PER + 2);

    // R7: continuous activity
    tx_act = 1;
    idle("R7", 3 * PER);
    tx_act = 0;
    idle("R7", PER + 2);

    // R3: scheme 10 with both speeds and blinking
    set_cfg(1, 0); speed_100 = 1;
    idle("R3", 2);
    pulse("R3", 1, 1);
    speed_100 = 0;
    idle("R3", PER);
    speed_100 = 1;
    idle("R3", 2);

    // R4: scheme 11 steady, activity ignored
    set_cfg(1, 1);
    rx_act = 1;
    idle("R4", PER + 2);
    rx_act = 0;
    speed_100 = 0;
    idle("R4", 2);

    // R5: scheme 01 steady, released speed LED
    set_cfg(0, 1); speed_100 = 1;
    pulse("R5", 1, 0);
    idle("R5", PER);

    // R10: switch to blinking mid period, visible next edge
    pulse("R10", 1, 0);
    idle("R10", 1);
    set_cfg(0, 0);
    idle("R10", 2);
    set_cfg(1, 1);
    idle("R10", 2);
    set_cfg(1, 0);
    idle("R10", PER);

    // R8: link drop mid blink clears timer, everything dark
    pulse("R8", 1, 0);
    idle("R8", 2);
    link_up = 0; tx_act = 1; speed_100 = 1;
    idle("R8", 4);
    tx_act = 0;
    link_up = 1;
    idle("R8", 1);
    pulse("R8", 0, 1);
    idle("R8", PER + 1);

    // R9: released LED stays low with link and speed high
    set_cfg(0, 0); speed_100 = 1;
    idle("R9", 3);

    // mixed pseudo-random run over all inputs
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 600; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        tx_act  = lf[0] & lf[3];
        rx_act  = lf[1] & lf[5] & lf[7];
        speed_100 = lf[2];
        if (lf[9:4] == 6'h00) link_up = ~link_up;
        if (lf[15:10] == 6'h3F) set_cfg(lf[11], lf[12]);
        step("R6");
      end
      tx_act = 0; rx_act = 0;
    end

    // R1: reset again mid activity
    link_up = 1; tx_act = 1; rst_n = 0;
    idle("R1", 2);
    tx_act = 0; rst_n = 1;
    idle("R1", 2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule